// File: doc/BRIEF.md
# Auto-Incrementing Coefficient RAM Loader

This block sits between a narrow host register port and a filter coefficient RAM. The host first programs a window into the RAM through two pointer registers, one for the first address and one for the last. It then streams coefficients through a single data register. Every access to the data register moves an internal word pointer one step toward the last address. A write access writes the current word. A read access returns the word stored at the pointer.

When the window covers a single address, the host can patch or inspect one RAM location with a single data access. When the host port runs in byte-wide mode, each coefficient takes two accesses, low byte first and then high byte. The RAM write happens only when the high byte completes the word. Reads advance the pointer exactly as writes do. A readback after a load therefore starts by rewriting the first-address register.

For a symmetric filter of NTAPS taps, the usual window ends at ceil(NTAPS/2) − 1. The words are loaded from the centre tap, ceil(NTAPS/2), outward to the tail.

Top module: `coef_loader`

## Requirements
- R1: After reset the pointer, the first-address register and the last-address register are all 0. The byte phase is low, `ram_we` is 0 and `host_rdata` is 0.
- R2: `ram_addr` always shows the pointer. A write to select 2'b00 loads both the first-address register and the pointer from `host_wdata`. A read of select 2'b00 or 2'b01 returns the first-address or last-address register, zero-extended, on `host_rdata` one cycle later.
- R3: In wide mode (`narrow_mode`=0), a write to select 2'b10 asserts `ram_we` in the same cycle, with `ram_wdata` equal to `host_wdata` at the pointer. The pointer then steps by one.
- R4: In wide mode, a read of select 2'b10 returns the RAM word at the pointer on `host_rdata` one cycle later. The pointer then steps by one.
- R5: Once the pointer equals the last-address register, further data accesses leave it unchanged. Repeated writes then land on that last address.
- R6: With the first address equal to the last address, one data write changes exactly that RAM location, and the pointer stays on it.
- R7: In byte mode, data writes alternate between low and high phases. The low write latches `host_wdata[7:0]` without asserting `ram_we`. The high write asserts `ram_we` with `ram_wdata` = {`host_wdata[COEF_W-9:0]`, latched low byte}, and then the pointer steps.
- R8: In byte mode, data reads alternate as well. The low-phase read returns bits [7:0] of the word. The high-phase read returns the upper bits, zero-extended. The pointer steps only after the high-phase read.
- R9: Writing the first-address register returns the byte phase to low, which discards any half-written word.
- R10: Select 2'b11 is reserved. Writes to it change no register and no RAM location, and reads of it return 0.
- R11: When `host_wr` and `host_rd` are both high, only the write takes effect, and `host_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_mode | input | 1 | 1 selects byte-wide host data accesses |
| host_wr | input | 1 | Host write strobe, one access per cycle high |
| host_rd | input | 1 | Host read strobe, one access per cycle high |
| host_addr | input | 2 | Register select: 00 first addr, 01 last addr, 10 data, 11 reserved |
| host_wdata | input | COEF_W | Host write data |
| host_rdata | output | COEF_W | Registered host read data |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address (the pointer) |
| ram_wdata | output | COEF_W | RAM write data |
| ram_rdata | input | COEF_W | RAM read data for `ram_addr`, combinational |

## Verification
The bench loads every RAM word in byte mode and reads it back. It checks that `ram_we` never fires on a low byte, since a design that wrote early would store half-formed words. It drives accesses past the last address, because a pointer that ran on would overwrite memory outside the window. It also covers a one-word window, where an off-by-one stop test would spill into the neighbour, and a half-written word cut off by a first-address write, where a missing phase reset would swap bytes. Simultaneous read/write strobes and the reserved select are checked for having no side effect on the pointer, the registers or the read data.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  typedef enum logic [1:0] {
    SEL_FIRST = 2'b00,
    SEL_LAST  = 2'b01,
    SEL_DATA  = 2'b10,
    SEL_RSVD  = 2'b11
  } host_sel_e;
endpackage

// File: rtl/coef_addr_ctrl.sv
module coef_addr_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_first,
  input  logic              load_last,
  input  logic [ADDR_W-1:0] din,
  input  logic              advance,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] last_q
);
  logic [ADDR_W-1:0] ptr_q, ptr_d, first_d, last_d;

  always_comb begin
    ptr_d   = ptr_q;
    first_d = first_q;
    last_d  = last_q;
    if (load_first) begin
      first_d = din;
      ptr_d   = din;
    end else if (advance && (ptr_q != last_q)) begin
      ptr_d = ptr_q + 1'b1;
    end
    if (load_last) last_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      ptr_q   <= ptr_d;
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  assign ptr = ptr_q;

  p_load_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_first |=> (ptr == $past(din)) && (first_q == $past(din)));
  p_hold_at_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load_first && !load_last && ptr == last_q) |=> ptr == $past(ptr));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load_first && ptr != last_q) |=> ptr == $past(ptr) + 1'b1);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load_first) |=> $stable(ptr));
endmodule

// File: rtl/coef_byte_pack.sv
module coef_byte_pack #(
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow,
  input  logic              clr_phase,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [COEF_W-1:0] wdata,
  input  logic [COEF_W-1:0] rword,
  output logic              phase_hi,
  output logic              word_done,
  output logic [COEF_W-1:0] ram_wdata,
  output logic [COEF_W-1:0] rd_value
);
  localparam int HI_W = COEF_W - 8;

  logic       phase_q, phase_d;
  logic [7:0] lo_q, lo_d;
  logic       access;

  assign access = data_wr || data_rd;

  always_comb begin
    phase_d = phase_q;
    lo_d    = lo_q;
    if (clr_phase || !narrow) begin
      phase_d = 1'b0;
    end else if (access) begin
      phase_d = ~phase_q;
    end
    if (narrow && data_wr && !phase_q) lo_d = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lo_q    <= '0;
    end else begin
      phase_q <= phase_d;
      lo_q    <= lo_d;
    end
  end

  assign phase_hi  = phase_q;
  assign word_done = access && (!narrow || phase_q);
  assign ram_wdata = narrow ? {wdata[HI_W-1:0], lo_q} : wdata;

  always_comb begin
    if (!narrow)      rd_value = rword;
    else if (phase_q) rd_value = {{8{1'b0}}, rword[COEF_W-1:8]};
    else              rd_value = {{HI_W{1'b0}}, rword[7:0]};
  end

  p_phase_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_phase |=> !phase_q);
  p_phase_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && access && !clr_phase) |=> phase_q != $past(phase_q));
endmodule

// File: rtl/coef_loader.sv
module coef_loader
  import coef_loader_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow_mode,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [COEF_W-1:0] host_wdata,
  output logic [COEF_W-1:0] host_rdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [COEF_W-1:0] ram_wdata,
  input  logic [COEF_W-1:0] ram_rdata
);
  localparam int PAD_W = COEF_W - ADDR_W;

  host_sel_e         sel;
  logic              rd_only, wr_first, wr_last, wr_data, rd_data;
  logic              phase_hi, word_done;
  logic [ADDR_W-1:0] ptr, first_q, last_q;
  logic [COEF_W-1:0] rd_value, rdata_q, rdata_d;

  assign sel      = host_sel_e'(host_addr);
  assign rd_only  = host_rd && !host_wr;
  assign wr_first = host_wr && (sel == SEL_FIRST);
  assign wr_last  = host_wr && (sel == SEL_LAST);
  assign wr_data  = host_wr && (sel == SEL_DATA);
  assign rd_data  = rd_only && (sel == SEL_DATA);

  coef_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_first (wr_first),
    .load_last  (wr_last),
    .din        (host_wdata[ADDR_W-1:0]),
    .advance    (word_done),
    .ptr        (ptr),
    .first_q    (first_q),
    .last_q     (last_q)
  );

  coef_byte_pack #(.COEF_W(COEF_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .narrow    (narrow_mode),
    .clr_phase (wr_first),
    .data_wr   (wr_data),
    .data_rd   (rd_data),
    .wdata     (host_wdata),
    .rword     (ram_rdata),
    .phase_hi  (phase_hi),
    .word_done (word_done),
    .ram_wdata (ram_wdata),
    .rd_value  (rd_value)
  );

  assign ram_addr = ptr;
  assign ram_we   = wr_data && word_done;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_only) begin
      case (sel)
        SEL_FIRST: rdata_d = {{PAD_W{1'b0}}, first_q};
        SEL_LAST:  rdata_d = {{PAD_W{1'b0}}, last_q};
        SEL_DATA:  rdata_d = rd_value;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign host_rdata = rdata_q;

  p_we_needs_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> host_wr);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rd) |=> $stable(host_rdata));
  p_we_high_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && narrow_mode) |-> phase_hi);
  p_rsvd_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && sel == SEL_RSVD) |=> $stable(ram_addr) && $stable(first_q) && $stable(last_q));
endmodule

// File: tb/tb_coef_loader.sv
module tb_coef_loader;
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk, rst_n, narrow_mode, host_wr, host_rd;
  logic [1:0]    host_addr;
  logic [CW-1:0] host_wdata, host_rdata, ram_wdata, ram_rdata;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [CW-1:0] mem [DEPTH];

  int n_cmp = 0;
  int n_bad = 0;
  logic          we_seen;
  logic [AW-1:0] addr_seen;
  logic [CW-1:0] wd_seen;

  coef_loader #(.ADDR_W(AW), .COEF_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic rd, input logic [1:0] sel,
                     input logic [CW-1:0] d);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_addr = sel; host_wdata = d;
    #1;
    we_seen = ram_we; addr_seen = ram_addr; wd_seen = ram_wdata;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  function automatic logic [CW-1:0] wval(input int i);
    return CW'(16'h1000 + i * 37);
  endfunction

  function automatic logic [CW-1:0] nval(input int i);
    return CW'(16'h5A00 ^ (i * 263));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    rst_n = 1'b0; narrow_mode = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_addr = 2'b00; host_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 addr", ram_addr, 0);
    chk("R1 rdata", host_rdata, 0);
    chk("R1 we", ram_we, 0);
    rst_n = 1'b1;
    acc(0, 1, 2'b00, 0); chk("R1 first", host_rdata, 0);
    acc(0, 1, 2'b01, 0); chk("R1 last", host_rdata, 0);

    // Wide window 5..12 with one overrun write
    acc(1, 0, 2'b00, 5); chk("R2 ptr load", ram_addr, 5);
    acc(1, 0, 2'b01, 12);
    acc(0, 1, 2'b00, 0); chk("R2 read first", host_rdata, 5);
    acc(0, 1, 2'b01, 0); chk("R2 read last", host_rdata, 12);
    for (int i = 0; i < 9; i++) begin
      acc(1, 0, 2'b10, wval(i));
      chk("R3 we", we_seen, 1);
      chk("R3 addr", addr_seen, (i < 8) ? 5 + i : 12);
      chk("R3 wdata", wd_seen, wval(i));
      chk("R5 ptr", ram_addr, (i < 7) ? 6 + i : 12);
    end
    for (int i = 0; i < 7; i++) chk("R3 mem", mem[5 + i], wval(i));
    chk("R5 overrun lands on last", mem[12], wval(8));
    chk("R5 beyond window untouched", mem[13], 0);
    acc(1, 0, 2'b00, 5);
    for (int i = 0; i < 8; i++) begin
      acc(0, 1, 2'b10, 0);
      chk("R4 read word", host_rdata, (i < 7) ? wval(i) : wval(8));
      chk("R4 ptr", ram_addr, (i < 7) ? 6 + i : 12);
    end

    // Single location
    for (int a = 29; a <= 31; a++) mem[a] = 16'h0F0F;
    acc(1, 0, 2'b00, 30); acc(1, 0, 2'b01, 30);
    acc(1, 0, 2'b10, 16'hC0DE);
    chk("R6 target", mem[30], 16'hC0DE);
    chk("R6 below", mem[29], 16'h0F0F);
    chk("R6 above", mem[31], 16'h0F0F);
    chk("R6 ptr", ram_addr, 30);

    // Byte mode full sweep
    narrow_mode = 1'b1;
    acc(1, 0, 2'b01, DEPTH - 1); acc(1, 0, 2'b00, 0);
    for (int i = 0; i < DEPTH; i++) begin
      acc(1, 0, 2'b10, {8'h00, nval(i)[7:0]});
      chk("R7 no we on low", we_seen, 0);
      chk("R7 ptr after low", ram_addr, i);
      acc(1, 0, 2'b10, {8'h00, nval(i)[15:8]});
      chk("R7 we on high", we_seen, 1);
      chk("R7 addr", addr_seen, i);
      chk("R7 word", wd_seen, nval(i));
    end
    for (int i = 0; i < DEPTH; i++) chk("R7 mem", mem[i], nval(i));
    acc(1, 0, 2'b00, 0);
    for (int i = 0; i < DEPTH; i++) begin
      acc(0, 1, 2'b10, 0);
      chk("R8 low byte", host_rdata, nval(i)[7:0]);
      chk("R8 ptr held", ram_addr, i);
      acc(0, 1, 2'b10, 0);
      chk("R8 high byte", host_rdata, nval(i)[15:8]);
      chk("R8 ptr step", ram_addr, (i < DEPTH - 1) ? i + 1 : DEPTH - 1);
    end

    // Phase reset by first-address write
    acc(1, 0, 2'b01, 40); acc(1, 0, 2'b00, 40);
    acc(1, 0, 2'b10, 16'h0011);
    acc(1, 0, 2'b00, 40);
    acc(1, 0, 2'b10, 16'h0022);
    chk("R9 low after reload no we", we_seen, 0);
    acc(1, 0, 2'b10, 16'h0033);
    chk("R9 word", mem[40], 16'h3322);

    // Simultaneous strobes and reserved select, wide mode
    narrow_mode = 1'b0;
    acc(1, 0, 2'b01, 20); acc(1, 0, 2'b00, 10);
    acc(0, 1, 2'b00, 0); chk("R2 first=10", host_rdata, 10);
    acc(1, 1, 2'b10, 16'hBEEF);
    chk("R11 write done", mem[10], 16'hBEEF);
    chk("R11 rdata held", host_rdata, 10);
    chk("R11 ptr", ram_addr, 11);
    acc(1, 0, 2'b11, 16'h0007);
    chk("R10 no we", we_seen, 0);
    chk("R10 ptr", ram_addr, 11);
    acc(0, 1, 2'b00, 0); chk("R10 first", host_rdata, 10);
    acc(0, 1, 2'b01, 0); chk("R10 last", host_rdata, 20);
    acc(0, 1, 2'b11, 0); chk("R10 read zero", host_rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule